// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block is the multi-cycle engine that an 8-bit microcontroller core hands its stack-based control transfers to. Once an operation is decoded, the core presents an operation code with its operands: the current PC, the instruction length, an immediate target, a table index, the register pair and the status word. It then pulses `start`. The sequencer owns the stack pointer. It moves bytes through a single byte-wide data memory port with combinational read data, and at the end it delivers the new PC, status word or register pair together with a one-cycle load strobe.

Supported operations:
- absolute call
- call through a vector table in page zero
- return
- return from interrupt
- push and pop of the status word
- push and pop of a register pair
- copying the register pair into SP, and SP into the register pair

Every operation occupies a fixed number of clock cycles whatever memory it touches. Cycles not spent on memory accesses are padded as wait states, so the core can keep its instruction timing exact. The core holds while `busy` is high and continues on `done`. A new operation may be started in the same cycle that `done` is shown.

Top module: `cr_stack_seq`

## Requirements
- R1: While reset is asserted and after it is released:
  - `busy`, `done`, `mem_we` and all three load strobes are low.
  - `sp` equals the parameter `SP_RESET` (default 16'hFE20).
- R2: `start` is accepted only when `busy` is low and `op_code` is a defined code. The defined codes are:
  - 0 absolute call
  - 1 table call
  - 2 return
  - 3 return from interrupt
  - 4 push status
  - 5 pop status
  - 6 push pair
  - 7 pop pair
  - 8 SP from pair
  - 9 pair from SP

  Codes 10 to 15, and any `start` while busy, start nothing, write no memory and leave `sp` unchanged.
- R3: After the accepting edge, `busy` stays high for exactly the operation's cycle count, and `done` is high for the single following cycle. `sp` does not change while `busy` is high. The cycle counts are:

  | Operation | Cycles |
  |---|---|
  | absolute call | 6 |
  | table call | 8 |
  | return | 6 |
  | return from interrupt | 8 |
  | push status | 2 |
  | pop status | 4 |
  | push pair | 4 |
  | pop pair | 6 |
  | SP from pair | 8 |
  | pair from SP | 6 |
- R4: Absolute call writes the high byte of `pc_cur + inst_len` to SP−1, then the low byte to SP−2. It loads `target` into the PC and lowers SP by 2.
- R5: Table call pushes `pc_cur + inst_len` the same way. It then reads the PC low byte from address {8'h00, tbl_idx} and the PC high byte from {8'h00, tbl_idx+1}, and lowers SP by 2.
- R6: Return reads the PC low byte from (SP) and the high byte from (SP+1), then raises SP by 2.
- R7: Return from interrupt does what return does, also loads the status word from (SP+2), and raises SP by 3.
- R8: Push status writes `stat_cur` to SP−1 and lowers SP by 1. Pop status loads the status word from (SP) and raises SP by 1.
- R9: Push pair writes the high byte of `pair_in` to SP−1, then the low byte to SP−2, and lowers SP by 2. Pop pair reads the low byte from (SP) and the high byte from (SP+1), then raises SP by 2.
- R10: SP-from-pair loads `pair_in` into SP. Pair-from-SP returns the current SP on `pair_new`.
- R11: All SP and stack address arithmetic wraps modulo 2^16.
- R12: The load strobes and their values:
  - `pc_load`, `stat_load` and `pair_load` are high only in the `done` cycle, and only for operations that produce that value.
  - `pc_new`, `stat_new` and `pair_new` carry the result in that cycle.
  - `mem_we` is high only while `busy` is high.
- R13: A `start` presented in the `done` cycle of the previous operation is accepted, and the new operation uses the SP just updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin the operation on `op_code` |
| op_code | input | 4 | Operation selector (codes in R2) |
| pc_cur | input | 16 | PC of the current instruction |
| inst_len | input | 2 | Length in bytes of the current instruction |
| target | input | 16 | Absolute call destination |
| tbl_idx | input | 8 | Page-zero vector table address (even) |
| pair_in | input | 16 | Register pair value |
| stat_cur | input | 8 | Current status word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 8 | Data memory write byte |
| mem_we | output | 1 | Data memory write enable |
| mem_rdata | input | 8 | Data memory read byte (combinational) |
| pc_new | output | 16 | New PC |
| pc_load | output | 1 | Load strobe for `pc_new` |
| sp | output | 16 | Stack pointer |
| stat_new | output | 8 | Restored status word |
| stat_load | output | 1 | Load strobe for `stat_new` |
| pair_new | output | 16 | New register pair value |
| pair_load | output | 1 | Load strobe for `pair_new` |

## Verification
The case that matters is when the completion of one operation and the acceptance of the next fall in the same cycle. In that cycle `done`, the load strobes and the SP update from the finishing operation coincide with `start` for the following one. The driver raises `start` in exactly the cycle where it sees `done`, for every operation in the run. The scoreboard then judges each new operation's memory addresses and final SP against a model SP chained from the previous result. A stale or double-applied SP shows up as a wrong write address or a wrong final SP. A second collision, `start` arriving while an operation is busy, is provoked once: the scoreboard must see no extra write and no change to the cycle count.

// File: rtl/cr_pkg.sv
package cr_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int OP_W    = 4;
    localparam int LEN_W   = 2;
    localparam int MAX_CYC = 8;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int OFF_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_CALL      = 4'd0,
        OP_CALL_TBL  = 4'd1,
        OP_RET       = 4'd2,
        OP_RET_INT   = 4'd3,
        OP_PUSH_ST   = 4'd4,
        OP_POP_ST    = 4'd5,
        OP_PUSH_PAIR = 4'd6,
        OP_POP_PAIR  = 4'd7,
        OP_SP_LOAD   = 4'd8,
        OP_SP_READ   = 4'd9
    } op_e;

    typedef enum logic [1:0] {ACC_IDLE, ACC_WRITE, ACC_READ} acc_kind_e;
    typedef enum logic {BASE_STACK, BASE_TABLE} base_e;
    typedef enum logic [2:0] {WS_RET_HI, WS_RET_LO, WS_STAT, WS_PAIR_HI, WS_PAIR_LO} wsrc_e;
    typedef enum logic [2:0] {DST_NONE, DST_PC_LO, DST_PC_HI, DST_STAT, DST_PAIR_LO, DST_PAIR_HI} dst_e;

    // one memory step: kind, base, signed offset, write source, read destination
    typedef struct packed {
        acc_kind_e        kind;
        base_e            base;
        logic [OFF_W-1:0] off;
        wsrc_e            src;
        dst_e             dst;
    } acc_t;

    function automatic acc_t mk_acc(input acc_kind_e k, input base_e b,
                                    input logic [OFF_W-1:0] o, input wsrc_e s,
                                    input dst_e d);
        acc_t a;
        a.kind = k;
        a.base = b;
        a.off  = o;
        a.src  = s;
        a.dst  = d;
        return a;
    endfunction

    // fixed clock count of every operation; zero marks an undefined code
    function automatic logic [CNT_W-1:0] op_cycles(input logic [OP_W-1:0] op);
        logic [CNT_W-1:0] n;
        case (op)
            OP_CALL:      n = CNT_W'(6);
            OP_CALL_TBL:  n = CNT_W'(8);
            OP_RET:       n = CNT_W'(6);
            OP_RET_INT:   n = CNT_W'(8);
            OP_PUSH_ST:   n = CNT_W'(2);
            OP_POP_ST:    n = CNT_W'(4);
            OP_PUSH_PAIR: n = CNT_W'(4);
            OP_POP_PAIR:  n = CNT_W'(6);
            OP_SP_LOAD:   n = CNT_W'(8);
            OP_SP_READ:   n = CNT_W'(6);
            default:      n = '0;
        endcase
        return n;
    endfunction

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return op_cycles(op) != '0;
    endfunction

endpackage

// File: rtl/cr_step_ctr.sv
module cr_step_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic [CNT_W-1:0] step,
    output logic             last
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] step;
        logic [CNT_W-1:0] len;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (c_q.busy) begin
            if (c_q.step == c_q.len - 1'b1) begin
                c_d.busy = 1'b0;
                c_d.step = '0;
            end else begin
                c_d.step = c_q.step + 1'b1;
            end
        end
        if (load) begin
            c_d.busy = 1'b1;
            c_d.step = '0;
            c_d.len  = len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy = c_q.busy;
    assign step = c_q.step;
    assign last = c_q.busy && (c_q.step == c_q.len - 1'b1);

    // R3
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy |-> (c_q.step < c_q.len));

    // R2
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && !last) |=> (c_q.len == $past(c_q.len)));

endmodule

// File: rtl/cr_plan.sv
module cr_plan
    import cr_pkg::*;
(
    input  op_e              op,
    input  logic [CNT_W-1:0] step,
    output acc_t             acc
);

    localparam logic [OFF_W-1:0] OFF_M2 = OFF_W'(-2);
    localparam logic [OFF_W-1:0] OFF_M1 = OFF_W'(-1);
    localparam logic [OFF_W-1:0] OFF_0  = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_P1 = OFF_W'(1);
    localparam logic [OFF_W-1:0] OFF_P2 = OFF_W'(2);

    acc_t idle_a;
    assign idle_a = mk_acc(ACC_IDLE, BASE_STACK, OFF_0, WS_STAT, DST_NONE);

    always_comb begin
        acc = idle_a;
        case (op)
            OP_CALL, OP_CALL_TBL: begin
                case (step)
                    CNT_W'(0): acc = mk_acc(ACC_WRITE, BASE_STACK, OFF_M1, WS_RET_HI, DST_NONE);
                    CNT_W'(1): acc = mk_acc(ACC_WRITE, BASE_STACK, OFF_M2, WS_RET_LO, DST_NONE);
                    CNT_W'(2): if (op == OP_CALL_TBL)
                                   acc = mk_acc(ACC_READ, BASE_TABLE, OFF_0, WS_STAT, DST_PC_LO);
                    CNT_W'(3): if (op == OP_CALL_TBL)
                                   acc = mk_acc(ACC_READ, BASE_TABLE, OFF_P1, WS_STAT, DST_PC_HI);
                    default:   acc = idle_a;
                endcase
            end
            OP_RET, OP_RET_INT: begin
                case (step)
                    CNT_W'(0): acc = mk_acc(ACC_READ, BASE_STACK, OFF_0, WS_STAT, DST_PC_LO);
                    CNT_W'(1): acc = mk_acc(ACC_READ, BASE_STACK, OFF_P1, WS_STAT, DST_PC_HI);
                    CNT_W'(2): if (op == OP_RET_INT)
                                   acc = mk_acc(ACC_READ, BASE_STACK, OFF_P2, WS_STAT, DST_STAT);
                    default:   acc = idle_a;
                endcase
            end
            OP_PUSH_ST: begin
                if (step == '0) acc = mk_acc(ACC_WRITE, BASE_STACK, OFF_M1, WS_STAT, DST_NONE);
            end
            OP_POP_ST: begin
                if (step == '0) acc = mk_acc(ACC_READ, BASE_STACK, OFF_0, WS_STAT, DST_STAT);
            end
            OP_PUSH_PAIR: begin
                case (step)
                    CNT_W'(0): acc = mk_acc(ACC_WRITE, BASE_STACK, OFF_M1, WS_PAIR_HI, DST_NONE);
                    CNT_W'(1): acc = mk_acc(ACC_WRITE, BASE_STACK, OFF_M2, WS_PAIR_LO, DST_NONE);
                    default:   acc = idle_a;
                endcase
            end
            OP_POP_PAIR: begin
                case (step)
                    CNT_W'(0): acc = mk_acc(ACC_READ, BASE_STACK, OFF_0, WS_STAT, DST_PAIR_LO);
                    CNT_W'(1): acc = mk_acc(ACC_READ, BASE_STACK, OFF_P1, WS_STAT, DST_PAIR_HI);
                    default:   acc = idle_a;
                endcase
            end
            default: acc = idle_a;
        endcase
    end

endmodule

// File: rtl/cr_stack_seq.sv
module cr_stack_seq
    import cr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SP_RESET = 16'hFE20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op_code,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [LEN_W-1:0]  inst_len,
    input  logic [ADDR_W-1:0] target,
    input  logic [DATA_W-1:0] tbl_idx,
    input  logic [ADDR_W-1:0] pair_in,
    input  logic [DATA_W-1:0] stat_cur,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc_new,
    output logic              pc_load,
    output logic [ADDR_W-1:0] sp,
    output logic [DATA_W-1:0] stat_new,
    output logic              stat_load,
    output logic [ADDR_W-1:0] pair_new,
    output logic              pair_load
);

    localparam int PAGE_W = ADDR_W - DATA_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] ret;
        logic [ADDR_W-1:0] tgt;
        logic [DATA_W-1:0] idx;
        logic [ADDR_W-1:0] pair;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] rd_pc_lo;
        logic [DATA_W-1:0] rd_pc_hi;
        logic [DATA_W-1:0] rd_stat;
        logic [DATA_W-1:0] rd_pr_lo;
        logic [DATA_W-1:0] rd_pr_hi;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] pc_out;
        logic [DATA_W-1:0] st_out;
        logic [ADDR_W-1:0] pr_out;
        logic              pc_ld;
        logic              st_ld;
        logic              pr_ld;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    logic             accept;
    logic             busy_w;
    logic             last_w;
    logic [CNT_W-1:0] step_w;
    logic [CNT_W-1:0] len_w;
    acc_t             acc_w;
    logic             rd_en;
    logic [ADDR_W-1:0] off_ext;
    logic [DATA_W-1:0] tbl_lo;

    assign len_w  = op_cycles(op_code);
    assign accept = start && !busy_w && op_known(op_code);

    cr_step_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .len   (len_w),
        .busy  (busy_w),
        .step  (step_w),
        .last  (last_w)
    );

    cr_plan u_plan (
        .op   (s_q.op),
        .step (step_w),
        .acc  (acc_w)
    );

    // memory port: stack accesses wrap in 64K, table accesses wrap in page zero
    assign off_ext = {{(ADDR_W-OFF_W){acc_w.off[OFF_W-1]}}, acc_w.off};
    assign tbl_lo  = s_q.idx + off_ext[DATA_W-1:0];
    assign rd_en   = busy_w && (acc_w.kind == ACC_READ);

    always_comb begin
        if (acc_w.base == BASE_TABLE) mem_addr = {{PAGE_W{1'b0}}, tbl_lo};
        else                          mem_addr = s_q.sp + off_ext;
        mem_we = busy_w && (acc_w.kind == ACC_WRITE);
        case (acc_w.src)
            WS_RET_HI:  mem_wdata = s_q.ret[ADDR_W-1:DATA_W];
            WS_RET_LO:  mem_wdata = s_q.ret[DATA_W-1:0];
            WS_STAT:    mem_wdata = s_q.stat;
            WS_PAIR_HI: mem_wdata = s_q.pair[ADDR_W-1:DATA_W];
            WS_PAIR_LO: mem_wdata = s_q.pair[DATA_W-1:0];
            default:    mem_wdata = '0;
        endcase
    end

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.pc_ld = 1'b0;
        s_d.st_ld = 1'b0;
        s_d.pr_ld = 1'b0;

        if (accept) begin
            s_d.op   = op_e'(op_code);
            s_d.ret  = pc_cur + ADDR_W'(inst_len);
            s_d.tgt  = target;
            s_d.idx  = tbl_idx;
            s_d.pair = pair_in;
            s_d.stat = stat_cur;
        end

        if (rd_en) begin
            case (acc_w.dst)
                DST_PC_LO:   s_d.rd_pc_lo = mem_rdata;
                DST_PC_HI:   s_d.rd_pc_hi = mem_rdata;
                DST_STAT:    s_d.rd_stat  = mem_rdata;
                DST_PAIR_LO: s_d.rd_pr_lo = mem_rdata;
                DST_PAIR_HI: s_d.rd_pr_hi = mem_rdata;
                default:     ;
            endcase
        end

        // final edge: every read has been captured in an earlier step
        if (busy_w && last_w) begin
            s_d.done = 1'b1;
            case (s_q.op)
                OP_CALL: begin
                    s_d.pc_out = s_q.tgt;
                    s_d.pc_ld  = 1'b1;
                    s_d.sp     = s_q.sp - ADDR_W'(2);
                end
                OP_CALL_TBL: begin
                    s_d.pc_out = {s_q.rd_pc_hi, s_q.rd_pc_lo};
                    s_d.pc_ld  = 1'b1;
                    s_d.sp     = s_q.sp - ADDR_W'(2);
                end
                OP_RET: begin
                    s_d.pc_out = {s_q.rd_pc_hi, s_q.rd_pc_lo};
                    s_d.pc_ld  = 1'b1;
                    s_d.sp     = s_q.sp + ADDR_W'(2);
                end
                OP_RET_INT: begin
                    s_d.pc_out = {s_q.rd_pc_hi, s_q.rd_pc_lo};
                    s_d.pc_ld  = 1'b1;
                    s_d.st_out = s_q.rd_stat;
                    s_d.st_ld  = 1'b1;
                    s_d.sp     = s_q.sp + ADDR_W'(3);
                end
                OP_PUSH_ST: begin
                    s_d.sp = s_q.sp - ADDR_W'(1);
                end
                OP_POP_ST: begin
                    s_d.st_out = s_q.rd_stat;
                    s_d.st_ld  = 1'b1;
                    s_d.sp     = s_q.sp + ADDR_W'(1);
                end
                OP_PUSH_PAIR: begin
                    s_d.sp = s_q.sp - ADDR_W'(2);
                end
                OP_POP_PAIR: begin
                    s_d.pr_out = {s_q.rd_pr_hi, s_q.rd_pr_lo};
                    s_d.pr_ld  = 1'b1;
                    s_d.sp     = s_q.sp + ADDR_W'(2);
                end
                OP_SP_LOAD: begin
                    s_d.sp = s_q.pair;
                end
                OP_SP_READ: begin
                    s_d.pr_out = s_q.sp;
                    s_d.pr_ld  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.op <= OP_CALL;
            s_q.sp <= SP_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = busy_w;
    assign done      = s_q.done;
    assign sp        = s_q.sp;
    assign pc_new    = s_q.pc_out;
    assign pc_load   = s_q.pc_ld;
    assign stat_new  = s_q.st_out;
    assign stat_load = s_q.st_ld;
    assign pair_new  = s_q.pr_out;
    assign pair_load = s_q.pr_ld;

    // checker state: busy cycles since the last accepted start
    logic [CNT_W:0] chk_cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chk_cyc_q <= '0;
        else if (accept) chk_cyc_q <= '0;
        else if (busy_w) chk_cyc_q <= chk_cyc_q + 1'b1;
    end

    // R3
    cyc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_cyc_q == {1'b0, op_cycles(s_q.op)}));

    // R3
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sp));

    // R12
    wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R12
    load_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load || stat_load || pair_load) |-> done);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R11
    call_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.op == OP_CALL) |-> (sp == $past(sp) - 16'd2));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/cr_stack_seq_bench.sv
module cr_stack_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  op_code;
    logic [15:0] pc_cur;
    logic [1:0]  inst_len;
    logic [15:0] target;
    logic [7:0]  tbl_idx;
    logic [15:0] pair_in;
    logic [7:0]  stat_cur;
    logic        busy, done, mem_we, pc_load, stat_load, pair_load;
    logic [15:0] mem_addr, pc_new, sp, pair_new;
    logic [7:0]  mem_wdata, mem_rdata, stat_new;

    always #10 clk = ~clk;

    cr_stack_seq u_cr_stack_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .pc_cur(pc_cur), .inst_len(inst_len), .target(target), .tbl_idx(tbl_idx),
        .pair_in(pair_in), .stat_cur(stat_cur), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .pc_new(pc_new), .pc_load(pc_load), .sp(sp),
        .stat_new(stat_new), .stat_load(stat_load), .pair_new(pair_new),
        .pair_load(pair_load)
    );

    // memory model, 1 KiB window indexed by the low address bits
    logic [7:0] mem [0:1023];
    logic       pre_we;
    logic [9:0] pre_a;
    logic [7:0] pre_d;
    always @(posedge clk) begin
        if (mem_we)      mem[mem_addr[9:0]] <= mem_wdata;
        else if (pre_we) mem[pre_a] <= pre_d;
    end
    assign mem_rdata = mem[mem_addr[9:0]];

    int n_cmp = 0;
    int n_bad = 0;
    bit fin = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
    } wr_t;

    typedef struct packed {
        logic        pcl;
        logic [15:0] pc;
        logic        sl;
        logic [7:0]  st;
        logic        rl;
        logic [15:0] pr;
        logic [15:0] sp;
        logic [7:0]  cyc;
    } res_t;

    wr_t   wr_q[$];
    string wtag_q[$];
    res_t  res_q[$];
    string tag_q[$];

    function automatic res_t mkres(input logic pcl, input logic [15:0] pc,
                                   input logic sl, input logic [7:0] st,
                                   input logic rl, input logic [15:0] pr,
                                   input logic [15:0] spv, input logic [7:0] cyc);
        res_t r;
        r.pcl = pcl; r.pc = pc; r.sl = sl; r.st = st;
        r.rl = rl; r.pr = pr; r.sp = spv; r.cyc = cyc;
        return r;
    endfunction

    task automatic push_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        wr_t w;
        w.a = a;
        w.d = d;
        wr_q.push_back(w);
        wtag_q.push_back(tag);
    endtask

    // monitor: compares writes and completions as they appear
    int    cyc_n = 0;
    wr_t   mw;
    res_t  mr;
    string mt;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) cyc_n++;
            if (mem_we) begin
                if (wr_q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R2 unexpected write actual=%h:%h expected=none", mem_addr, mem_wdata);
                end else begin
                    mw = wr_q.pop_front();
                    mt = wtag_q.pop_front();
                    check({mt, " addr"}, 32'(mem_addr), 32'(mw.a));
                    check({mt, " data"}, 32'(mem_wdata), 32'(mw.d));
                end
            end
            if (done) begin
                if (res_q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R3 unexpected done actual=1 expected=0");
                end else begin
                    mr = res_q.pop_front();
                    mt = tag_q.pop_front();
                    check({mt, " R3 cycles"}, 32'(cyc_n), 32'(mr.cyc));
                    check({mt, " sp"}, 32'(sp), 32'(mr.sp));
                    check({mt, " R12 pc_load"}, 32'(pc_load), 32'(mr.pcl));
                    check({mt, " R12 stat_load"}, 32'(stat_load), 32'(mr.sl));
                    check({mt, " R12 pair_load"}, 32'(pair_load), 32'(mr.rl));
                    if (mr.pcl) check({mt, " pc_new"}, 32'(pc_new), 32'(mr.pc));
                    if (mr.sl)  check({mt, " stat_new"}, 32'(stat_new), 32'(mr.st));
                    if (mr.rl)  check({mt, " pair_new"}, 32'(pair_new), 32'(mr.pr));
                end
                cyc_n = 0;
            end
        end
    end

    // driver: raises start in the cycle it is called (the previous done cycle)
    task automatic issue(input logic [3:0] op, input logic [15:0] pc, input logic [1:0] len,
                         input logic [15:0] tgt, input logic [7:0] idx, input logic [15:0] pair,
                         input logic [7:0] st, input res_t r, input string tag, input bit inj);
        res_q.push_back(r);
        tag_q.push_back(tag);
        op_code  = op;
        pc_cur   = pc;
        inst_len = len;
        target   = tgt;
        tbl_idx  = idx;
        pair_in  = pair;
        stat_cur = st;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check({tag, " R13 accepted"}, 32'(busy), 32'd1);
        if (inj) begin
            op_code  = 4'd4;
            stat_cur = 8'hEE;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; op_code = '0; pc_cur = '0; inst_len = '0;
        target = '0; tbl_idx = '0; pair_in = '0; stat_cur = '0;
        pre_we = 1'b0; pre_a = '0; pre_d = '0;
        repeat (2) @(negedge clk);
        // vector table entry at 0x0040: low 0x78, high 0x56
        pre_we = 1'b1; pre_a = 10'h040; pre_d = 8'h78;
        @(negedge clk);
        pre_a = 10'h041; pre_d = 8'h56;
        @(negedge clk);
        pre_we = 1'b0;
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 done in reset", 32'(done), 32'd0);
        check("R1 sp in reset", 32'(sp), 32'hFE20);
        check("R1 mem_we in reset", 32'(mem_we), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 32'd0);
        check("R1 sp after reset", 32'(sp), 32'hFE20);
        check("R1 strobes after reset", 32'({pc_load, stat_load, pair_load}), 32'd0);

        push_wr(16'hFE1F, 8'h12, "R9 push pair hi");
        push_wr(16'hFE1E, 8'h34, "R9 push pair lo");
        issue(4'd6, 0, 0, 0, 0, 16'h1234, 0, mkres(0,0,0,0,0,0,16'hFE1E,4), "R9 push pair", 0);

        push_wr(16'hFE1D, 8'hA5, "R8 push status");
        issue(4'd4, 0, 0, 0, 0, 0, 8'hA5, mkres(0,0,0,0,0,0,16'hFE1D,2), "R8 push status", 0);

        issue(4'd5, 0, 0, 0, 0, 0, 0, mkres(0,0,1,8'hA5,0,0,16'hFE1E,4), "R8 pop status", 0);

        issue(4'd7, 0, 0, 0, 0, 0, 0, mkres(0,0,0,0,1,16'h1234,16'hFE20,6), "R9 pop pair", 0);

        push_wr(16'hFE1F, 8'h10, "R4 call hi");
        push_wr(16'hFE1E, 8'h03, "R4 call lo");
        issue(4'd0, 16'h1000, 2'd3, 16'h2345, 0, 0, 0, mkres(1,16'h2345,0,0,0,0,16'hFE1E,6), "R4 call", 0);

        issue(4'd2, 0, 0, 0, 0, 0, 0, mkres(1,16'h1003,0,0,0,0,16'hFE20,6), "R6 return", 0);

        push_wr(16'hFE1F, 8'h30, "R5 table call hi");
        push_wr(16'hFE1E, 8'h01, "R5 table call lo");
        issue(4'd1, 16'h3000, 2'd1, 0, 8'h40, 0, 0, mkres(1,16'h5678,0,0,0,0,16'hFE1E,8), "R5 table call", 0);

        issue(4'd2, 0, 0, 0, 0, 0, 0, mkres(1,16'h3001,0,0,0,0,16'hFE20,6), "R6 return", 0);

        push_wr(16'hFE1F, 8'h3C, "R8 push status");
        issue(4'd4, 0, 0, 0, 0, 0, 8'h3C, mkres(0,0,0,0,0,0,16'hFE1F,2), "R8 push status", 0);

        push_wr(16'hFE1E, 8'h40, "R4 call hi");
        push_wr(16'hFE1D, 8'h03, "R4 call lo");
        issue(4'd0, 16'h4000, 2'd3, 16'h0100, 0, 0, 0, mkres(1,16'h0100,0,0,0,0,16'hFE1D,6), "R4 call", 0);

        issue(4'd3, 0, 0, 0, 0, 0, 0, mkres(1,16'h4003,1,8'h3C,0,0,16'hFE20,8), "R7 return from interrupt", 0);

        issue(4'd8, 0, 0, 0, 0, 16'h0001, 0, mkres(0,0,0,0,0,0,16'h0001,8), "R10 sp from pair", 0);

        push_wr(16'h0000, 8'h12, "R11 call hi");
        push_wr(16'hFFFF, 8'h37, "R11 call lo wrapped");
        issue(4'd0, 16'h1234, 2'd3, 16'hABCD, 0, 0, 0, mkres(1,16'hABCD,0,0,0,0,16'hFFFF,6), "R11 call wrap", 0);

        issue(4'd2, 0, 0, 0, 0, 0, 0, mkres(1,16'h1237,0,0,0,0,16'h0001,6), "R11 return wrap", 0);

        issue(4'd9, 0, 0, 0, 0, 16'hDEAD, 0, mkres(0,0,0,0,1,16'h0001,16'h0001,6), "R10 pair from sp", 0);

        issue(4'd8, 0, 0, 0, 0, 16'hFE20, 0, mkres(0,0,0,0,0,0,16'hFE20,8), "R10 sp from pair", 0);

        push_wr(16'hFE1F, 8'hBE, "R2 push pair hi");
        push_wr(16'hFE1E, 8'hEF, "R2 push pair lo");
        issue(4'd6, 0, 0, 0, 0, 16'hBEEF, 0, mkres(0,0,0,0,0,0,16'hFE1E,4), "R2 start while busy", 1);
        @(negedge clk);
        check("R2 no op after busy start", 32'(busy), 32'd0);
        @(negedge clk);
        check("R2 no op after busy start", 32'(busy), 32'd0);

        op_code = 4'hC;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 undefined code busy", 32'(busy), 32'd0);
        check("R2 undefined code sp", 32'(sp), 32'hFE1E);
        @(negedge clk);
        check("R2 undefined code done", 32'(done), 32'd0);
        check("R2 undefined code busy", 32'(busy), 32'd0);

        issue(4'd7, 0, 0, 0, 0, 0, 0, mkres(0,0,0,0,1,16'hBEEF,16'hFE20,6), "R9 pop pair", 0);

        repeat (3) @(negedge clk);
        check("R12 pending writes", 32'(wr_q.size()), 32'd0);
        check("R3 pending results", 32'(res_q.size()), 32'd0);
        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!fin) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule